// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is the register-level front end of an I2C master. Software loads a byte into the buffer register and then writes a command word in which any combination of five request bits may be set: START, TX, RX, RX-last and STOP. The block runs the requested phases one after another in a fixed order. It hands each phase to a byte-level I2C engine over a request/acknowledge handshake, and it records the outcome of each phase in a write-1-to-clear interrupt status register.

A 4-bit state field inside the command register follows the transfer. Bit 3 of that field marks every in-transfer state. This bit is what turns a START into a repeated start, and what decides whether a STOP is a normal stop or an abnormal one. A single interrupt line combines the status bits with an enable register. The line is only allowed high once every phase of the current command has finished.

Sequencer states: IDLE (waits for an accepted command write), PICK (selects the highest-priority pending bit, or returns to IDLE when none is left), ADDR (START request), SEND (TX request), END (stop request after a data NAK), RECV (receive request) and STOP (stop request). Transitions: IDLE→PICK on an accepted write; PICK→ADDR/SEND/RECV/STOP according to priority; PICK→PICK on an abnormal STOP; every request state→PICK on acknowledge, except SEND→END on a NAK; PICK→IDLE when no request bit is left.

Top module: `i2c_cmd_seq`

## Requirements
- R1: Register map. Address 0 is the command register: request bits in [15:0], with START at bit 0, TX at bit 1, RX at bit 2, RX-last at bit 3 and STOP at bit 4, and the state field read-only in [19:16]. Address 1 is the buffer: transmit byte in [7:0], received byte in [15:8] (read-only). Address 2 is the status register. Address 3 is the enable register. An accepted command write replaces bits [15:0] and clears status bits [5:0].
- R2: Pending bits are serviced in the order START, TX, RX/RX-last, STOP. Each phase makes one engine request and holds it until acknowledge. Engine op codes are 0 start, 1 send, 2 receive, 3 stop. Each bit is cleared when its phase ends.
- R3: START presents buffer byte [7:0] (address in [7:1], direction in bit 0) on eng_wdata. Afterward both START and TX are cleared, so no separate send follows.
- R4: START moves the state field to 0x9 (repeated start) when state bit 3 is set, and to 0x1 otherwise.
- R5: If the address byte is NAKed, status bit 1 is set, every remaining request bit is dropped and the state field keeps its start code. If it is ACKed, status bit 0 is set and the state becomes 0x8.
- R6: TX uses state 0xA and sends buffer byte [7:0]. On NAK it sets status bit 1 and then issues a stop request to end the transfer. On ACK it sets status bit 0. In both cases the state ends at 0x8.
- R7: RX uses state 0xB and places the received byte in buffer [15:8], setting status bit 2. If the engine reports a read error, 0xFF is stored and bit 2 stays clear. The state ends at 0x8.
- R8: When RX-last is set, eng_last is 1 during the receive. RX and RX-last set together produce exactly one receive.
- R9: STOP with state bit 3 set issues a stop request through state 0x2 and sets status bit 3. STOP without state bit 3 makes no request and sets status bit 4. The state then becomes 0x0.
- R10: Status bits [5:0] are write-1-to-clear. Status bit 6 is a read-only busy indication.
- R11: irq is the OR of status[5:0] AND enable[5:0], and is held low while a command is running.
- R12: A command write that arrives while a command is running changes neither the request bits nor the engine activity, and sets sticky status bit 5.
- R13: After reset all registers read zero, the state is 0x0, irq is 0 and no engine request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt line |
| eng_req | output | 1 | Engine request, held until acknowledge |
| eng_op | output | 2 | Engine operation code |
| eng_wdata | output | 8 | Byte for start or send |
| eng_last | output | 1 | Answer the received byte with NACK |
| eng_ack | input | 1 | Engine completion pulse |
| eng_nak | input | 1 | Address or data byte was NAKed |
| eng_rdata | input | 8 | Received byte |
| eng_rerr | input | 1 | Receive failed |

## Verification
The bench targets phase ordering when several bits are set at once. A design that skipped priority or cleared bits too late would issue engine operations out of order, or issue some twice. An address NAK must abandon the later phases, and the next test is whether a following STOP then counts as abnormal; a design that kept stale request bits would still issue a receive or a stop. START from an active state must leave code 0x9 rather than 0x1. A read error must store 0xFF without RX-done. A write made while busy must neither reach the engine nor wipe the status, or else the first command's flags would disappear.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
    localparam int CMD_W  = 16;
    localparam int BYTE_W = 8;
    localparam int ST_W   = 4;
    localparam int FLAG_W = 6;
    localparam int ST_ACT_BIT = 3;

    localparam int CB_START = 0;
    localparam int CB_TX    = 1;
    localparam int CB_RX    = 2;
    localparam int CB_RXL   = 3;
    localparam int CB_STOP  = 4;

    localparam int FL_TXACK   = 0;
    localparam int FL_TXNAK   = 1;
    localparam int FL_RXDONE  = 2;
    localparam int FL_STOPOK  = 3;
    localparam int FL_STOPBAD = 4;
    localparam int FL_DROP    = 5;

    localparam logic [1:0] RA_CMD  = 2'd0;
    localparam logic [1:0] RA_BUF  = 2'd1;
    localparam logic [1:0] RA_STAT = 2'd2;
    localparam logic [1:0] RA_EN   = 2'd3;

    typedef enum logic [ST_W-1:0] {
        ST_IDLE    = 4'h0,
        ST_START   = 4'h1,
        ST_STOP    = 4'h2,
        ST_ACTIVE  = 4'h8,
        ST_RESTART = 4'h9,
        ST_TXD     = 4'hA,
        ST_RXD     = 4'hB
    } st_e;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_SEND  = 2'd1,
        OP_RECV  = 2'd2,
        OP_STOP  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_PICK, SQ_ADDR, SQ_SEND, SQ_END, SQ_RECV, SQ_STOP
    } seq_e;
endpackage

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
    import i2c_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [CMD_W-1:0]  go_cmd,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic [CMD_W-1:0]  cmd_bits,
    output logic [ST_W-1:0]   state_f,
    output logic              running,
    output logic [FLAG_W-1:0] set_flags,
    output logic              rx_we,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              eng_req,
    output logic [1:0]        eng_op,
    output logic [BYTE_W-1:0] eng_wdata,
    output logic              eng_last,
    input  logic              eng_ack,
    input  logic              eng_nak,
    input  logic [BYTE_W-1:0] eng_rdata,
    input  logic              eng_rerr
);
    localparam logic [CMD_W-1:0] M_START = CMD_W'(1) << CB_START;
    localparam logic [CMD_W-1:0] M_TX    = CMD_W'(1) << CB_TX;
    localparam logic [CMD_W-1:0] M_RX    = CMD_W'(1) << CB_RX;
    localparam logic [CMD_W-1:0] M_RXL   = CMD_W'(1) << CB_RXL;
    localparam logic [CMD_W-1:0] M_STOP  = CMD_W'(1) << CB_STOP;
    localparam logic [CMD_W-1:0] M_ALL   = M_START | M_TX | M_RX | M_RXL | M_STOP;

    seq_e             seq_q, seq_d;
    st_e              st_q, st_d;
    logic [CMD_W-1:0] cmd_q, cmd_d;

    // next-state and phase bookkeeping
    always_comb begin
        seq_d     = seq_q;
        st_d      = st_q;
        cmd_d     = cmd_q;
        set_flags = '0;
        rx_we     = 1'b0;
        rx_byte   = eng_rerr ? {BYTE_W{1'b1}} : eng_rdata;
        unique case (seq_q)
            SQ_IDLE: begin
                if (go) begin
                    cmd_d = go_cmd;
                    seq_d = SQ_PICK;
                end
            end
            SQ_PICK: begin
                if (cmd_q[CB_START]) begin
                    seq_d = SQ_ADDR;
                    st_d  = st_q[ST_ACT_BIT] ? ST_RESTART : ST_START;
                end else if (cmd_q[CB_TX]) begin
                    seq_d = SQ_SEND;
                    st_d  = ST_TXD;
                end else if (cmd_q[CB_RX] || cmd_q[CB_RXL]) begin
                    seq_d = SQ_RECV;
                    st_d  = ST_RXD;
                end else if (cmd_q[CB_STOP]) begin
                    if (st_q[ST_ACT_BIT]) begin
                        seq_d = SQ_STOP;
                        st_d  = ST_STOP;
                    end else begin
                        set_flags[FL_STOPBAD] = 1'b1;
                        cmd_d = cmd_q & ~M_STOP;
                        st_d  = ST_IDLE;
                    end
                end else begin
                    seq_d = SQ_IDLE;
                end
            end
            SQ_ADDR: begin
                if (eng_ack) begin
                    if (eng_nak) begin
                        set_flags[FL_TXNAK] = 1'b1;
                        cmd_d = cmd_q & ~M_ALL;
                    end else begin
                        set_flags[FL_TXACK] = 1'b1;
                        cmd_d = cmd_q & ~(M_START | M_TX);
                        st_d  = ST_ACTIVE;
                    end
                    seq_d = SQ_PICK;
                end
            end
            SQ_SEND: begin
                if (eng_ack) begin
                    cmd_d = cmd_q & ~M_TX;
                    if (eng_nak) begin
                        set_flags[FL_TXNAK] = 1'b1;
                        seq_d = SQ_END;
                    end else begin
                        set_flags[FL_TXACK] = 1'b1;
                        st_d  = ST_ACTIVE;
                        seq_d = SQ_PICK;
                    end
                end
            end
            SQ_END: begin
                if (eng_ack) begin
                    st_d  = ST_ACTIVE;
                    seq_d = SQ_PICK;
                end
            end
            SQ_RECV: begin
                if (eng_ack) begin
                    rx_we = 1'b1;
                    set_flags[FL_RXDONE] = !eng_rerr;
                    cmd_d = cmd_q & ~(M_RX | M_RXL);
                    st_d  = ST_ACTIVE;
                    seq_d = SQ_PICK;
                end
            end
            SQ_STOP: begin
                if (eng_ack) begin
                    set_flags[FL_STOPOK] = 1'b1;
                    cmd_d = cmd_q & ~M_STOP;
                    st_d  = ST_IDLE;
                    seq_d = SQ_PICK;
                end
            end
            default: seq_d = SQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= SQ_IDLE;
            st_q  <= ST_IDLE;
            cmd_q <= '0;
        end else begin
            seq_q <= seq_d;
            st_q  <= st_d;
            cmd_q <= cmd_d;
        end
    end

    // outputs
    always_comb begin
        eng_req = 1'b0;
        eng_op  = OP_START;
        unique case (seq_q)
            SQ_ADDR: begin eng_req = 1'b1; eng_op = OP_START; end
            SQ_SEND: begin eng_req = 1'b1; eng_op = OP_SEND;  end
            SQ_RECV: begin eng_req = 1'b1; eng_op = OP_RECV;  end
            SQ_END,
            SQ_STOP: begin eng_req = 1'b1; eng_op = OP_STOP;  end
            default: begin eng_req = 1'b0; eng_op = OP_START; end
        endcase
        eng_wdata = tx_byte;
        eng_last  = cmd_q[CB_RXL];
        cmd_bits  = cmd_q;
        state_f   = st_q;
        running   = (seq_q != SQ_IDLE);
    end

    // R2: a request stays up with the same op until acknowledged
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_ack) |=> (eng_req && $stable(eng_op)));

    // R9: an acknowledged stop phase leaves the state field idle
    a_r9_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q == SQ_STOP && eng_ack) |=> (state_f == ST_IDLE));

    // R12: the register file only launches a command while idle
    a_r12_go_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (seq_q == SQ_IDLE));
endmodule

// File: rtl/i2c_seq_regs.sv
module i2c_seq_regs
    import i2c_seq_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [1:0]        rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic              irq,
    input  logic [CMD_W-1:0]  cmd_bits,
    input  logic [ST_W-1:0]   state_f,
    input  logic              running,
    input  logic [FLAG_W-1:0] set_flags,
    input  logic              rx_we,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              go,
    output logic [CMD_W-1:0]  go_cmd,
    output logic [BYTE_W-1:0] tx_byte
);
    localparam int CMD_PAD  = REG_W - CMD_W - ST_W;
    localparam int BUF_PAD  = REG_W - 2 * BYTE_W;
    localparam int STAT_PAD = REG_W - FLAG_W - 1;
    localparam int EN_PAD   = REG_W - FLAG_W;

    logic [BYTE_W-1:0] tx_q, rx_q;
    logic [FLAG_W-1:0] status_q, en_q, set_all;
    logic              cmd_wr, stat_wr, drop;

    assign cmd_wr  = wr_en && (wr_addr == RA_CMD);
    assign stat_wr = wr_en && (wr_addr == RA_STAT);
    assign go      = cmd_wr && !running;
    assign drop    = cmd_wr && running;
    assign go_cmd  = wr_data[CMD_W-1:0];
    assign tx_byte = tx_q;
    assign set_all = set_flags | (FLAG_W'(drop) << FL_DROP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
            en_q <= '0;
        end else begin
            if (wr_en && wr_addr == RA_BUF) tx_q <= wr_data[BYTE_W-1:0];
            if (wr_en && wr_addr == RA_EN)  en_q <= wr_data[FLAG_W-1:0];
            if (rx_we)                      rx_q <= rx_byte;
        end
    end

    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
        logic bit_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                   bit_q <= 1'b0;
            else if (go)                  bit_q <= 1'b0;
            else if (set_all[i])          bit_q <= 1'b1;
            else if (stat_wr && wr_data[i]) bit_q <= 1'b0;
        end
        assign status_q[i] = bit_q;
    end

    assign irq = (|(status_q & en_q)) && !running;

    always_comb begin
        unique case (rd_addr)
            RA_CMD:  rd_data = {{CMD_PAD{1'b0}}, state_f, cmd_bits};
            RA_BUF:  rd_data = {{BUF_PAD{1'b0}}, rx_q, tx_q};
            RA_STAT: rd_data = {{STAT_PAD{1'b0}}, running, status_q};
            default: rd_data = {{EN_PAD{1'b0}}, en_q};
        endcase
    end

    // R1: an accepted command write leaves the status register clear
    a_r1_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (status_q == '0));

    // R2: each completed phase reports at most one outcome flag
    a_r2_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_flags));
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
    import i2c_seq_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [REG_W-1:0] rd_data,
    output logic             irq,
    output logic             eng_req,
    output logic [1:0]       eng_op,
    output logic [7:0]       eng_wdata,
    output logic             eng_last,
    input  logic             eng_ack,
    input  logic             eng_nak,
    input  logic [7:0]       eng_rdata,
    input  logic             eng_rerr
);
    logic              go, running, rx_we;
    logic [CMD_W-1:0]  go_cmd, cmd_bits;
    logic [ST_W-1:0]   state_f;
    logic [FLAG_W-1:0] set_flags;
    logic [BYTE_W-1:0] rx_byte, tx_byte;

    i2c_seq_regs #(.REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
        .cmd_bits(cmd_bits), .state_f(state_f), .running(running),
        .set_flags(set_flags), .rx_we(rx_we), .rx_byte(rx_byte),
        .go(go), .go_cmd(go_cmd), .tx_byte(tx_byte)
    );

    i2c_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .go(go), .go_cmd(go_cmd), .tx_byte(tx_byte),
        .cmd_bits(cmd_bits), .state_f(state_f), .running(running),
        .set_flags(set_flags), .rx_we(rx_we), .rx_byte(rx_byte),
        .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata),
        .eng_last(eng_last), .eng_ack(eng_ack), .eng_nak(eng_nak),
        .eng_rdata(eng_rdata), .eng_rerr(eng_rerr)
    );
endmodule

// File: tb/tb_i2c_cmd_seq.sv
module tb_i2c_cmd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq, eng_req, eng_last;
    logic [1:0]  eng_op;
    logic [7:0]  eng_wdata;
    logic        eng_ack = 1'b0, eng_nak = 1'b0, eng_rerr = 1'b0;
    logic [7:0]  eng_rdata = '0;

    always #2.5 clk = ~clk;

    i2c_cmd_seq dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
        .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata),
        .eng_last(eng_last), .eng_ack(eng_ack), .eng_nak(eng_nak),
        .eng_rdata(eng_rdata), .eng_rerr(eng_rerr)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // engine response configuration
    bit       c_addr_nak, c_data_nak, c_rerr;
    logic [7:0] c_rx;
    int       c_delay;

    // engine log
    logic [1:0] l_op [16];
    logic       l_last [16];
    logic [7:0] l_wd [16];
    int         l_n;

    // expected model
    logic [1:0] e_op [16];
    logic       e_last [16];
    int         e_n;
    logic [5:0] e_flags;
    logic [3:0] e_st;
    logic [7:0] e_rx;
    logic [7:0] tx;

    initial begin : engine
        forever begin
            @(negedge clk);
            eng_ack = 1'b0;
            if (eng_req && rst_n) begin
                if (l_n < 16) begin
                    l_op[l_n] = eng_op; l_last[l_n] = eng_last; l_wd[l_n] = eng_wdata;
                end
                l_n++;
                repeat (c_delay) @(negedge clk);
                eng_nak   = (eng_op == 2'd0) ? c_addr_nak : (eng_op == 2'd1) ? c_data_nak : 1'b0;
                eng_rdata = c_rx;
                eng_rerr  = c_rerr;
                eng_ack   = 1'b1;
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        for (int i = 0; i < 400; i++) begin
            rd(2'd2, d);
            if (!d[6]) return;
        end
        chk("R10 busy never cleared", 32'd1, 32'd0);
    endtask

    task automatic push(input logic [1:0] op, input logic last);
        e_op[e_n] = op; e_last[e_n] = last; e_n++;
    endtask

    task automatic model_cmd(input logic [4:0] c0);
        logic [4:0] c;
        c = c0; e_n = 0; e_flags = '0;
        if (c[0]) begin
            e_st = e_st[3] ? 4'h9 : 4'h1;
            push(2'd0, 1'b0);
            if (c_addr_nak) begin
                e_flags[1] = 1'b1;
                return;
            end
            e_flags[0] = 1'b1; e_st = 4'h8; c[1] = 1'b0;
        end
        if (c[1]) begin
            push(2'd1, 1'b0);
            if (c_data_nak) begin e_flags[1] = 1'b1; push(2'd3, 1'b0); end
            else e_flags[0] = 1'b1;
            e_st = 4'h8;
        end
        if (c[2] || c[3]) begin
            push(2'd2, c[3]);
            e_rx = c_rerr ? 8'hFF : c_rx;
            if (!c_rerr) e_flags[2] = 1'b1;
            e_st = 4'h8;
        end
        if (c[4]) begin
            if (e_st[3]) begin push(2'd3, 1'b0); e_flags[3] = 1'b1; end
            else e_flags[4] = 1'b1;
            e_st = 4'h0;
        end
    endtask

    task automatic compare(input string tag, input logic [5:0] en, input logic [5:0] extra);
        logic [31:0] d;
        rd(2'd2, d);
        chk({tag, " R1/R5/R6/R7/R9 status"}, {25'd0, d[6:0]}, {25'd0, 1'b0, e_flags | extra});
        rd(2'd0, d);
        chk({tag, " R4 state field"}, {28'd0, d[19:16]}, {28'd0, e_st});
        chk({tag, " R2 request bits cleared"}, {27'd0, d[4:0]}, 32'd0);
        rd(2'd1, d);
        chk({tag, " R7 rx byte"}, {24'd0, d[15:8]}, {24'd0, e_rx});
        chk({tag, " R2 op count"}, l_n, e_n);
        for (int k = 0; k < e_n && k < l_n && k < 16; k++) begin
            chk({tag, " R2 op order"}, {30'd0, l_op[k]}, {30'd0, e_op[k]});
            chk({tag, " R3 wdata"}, {24'd0, l_wd[k]}, {24'd0, tx});
            if (e_op[k] == 2'd2) chk({tag, " R8 last flag"}, {31'd0, l_last[k]}, {31'd0, e_last[k]});
        end
        @(negedge clk); #1;
        chk({tag, " R11 irq"}, {31'd0, irq}, {31'd0, |((e_flags | extra) & en)});
    endtask

    task automatic run(input string tag, input logic [4:0] c, input logic [5:0] en);
        wr(2'd3, {26'd0, en});
        wr(2'd1, {24'd0, tx});
        l_n = 0;
        model_cmd(c);
        wr(2'd0, {27'd0, c});
        wait_idle();
        compare(tag, en, 6'd0);
    endtask

    initial begin : stim
        logic [31:0] d;
        void'($urandom(32'h1C2A_5EED));
        c_addr_nak = 0; c_data_nak = 0; c_rerr = 0; c_rx = 8'h00; c_delay = 1;
        l_n = 0; e_st = 4'h0; e_rx = 8'h00; tx = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R13 reset state
        rd(2'd0, d); chk("R13 cmd after reset", d, 32'd0);
        rd(2'd1, d); chk("R13 buf after reset", d, 32'd0);
        rd(2'd2, d); chk("R13 status after reset", d, 32'd0);
        rd(2'd3, d); chk("R13 enable after reset", d, 32'd0);
        chk("R13 irq/req after reset", {30'd0, irq, eng_req}, 32'd0);

        // R9 abnormal stop from idle, R1 undefined bits kept in [15:0]
        tx = 8'h00; l_n = 0; model_cmd(5'h10);
        wr(2'd3, 32'h3F);
        wr(2'd0, 32'h0000_0110);
        wait_idle();
        rd(2'd0, d); chk("R1 undefined command bit retained", {16'd0, d[15:0]}, 32'h0000_0100);
        chk("R9 abnormal stop no engine op", l_n, 0);
        rd(2'd2, d); chk("R9 abnormal stop flag", {26'd0, d[5:0]}, 32'h10);
        chk("R11 irq on abnormal stop", {31'd0, irq}, 32'd1);
        wr(2'd0, 32'h0);
        wait_idle();
        rd(2'd0, d); chk("R1 write replaces low bits", {16'd0, d[15:0]}, 32'd0);
        rd(2'd2, d); chk("R1 status cleared by write", {26'd0, d[5:0]}, 32'd0);

        // full transfer: start, receive last, stop
        tx = 8'hA1; c_rx = 8'h5C;
        run("full", 5'h1D, 6'h3F);

        // R4 repeated start code: active then START with address NAK
        tx = 8'h42; run("open", 5'h03, 6'h00);
        c_addr_nak = 1; run("R4 restart nak", 5'h15, 6'h02);
        rd(2'd0, d); chk("R4 restart code", {28'd0, d[19:16]}, 32'h9);
        c_addr_nak = 0;
        // R5 NAK from idle keeps plain start code; stop afterward is abnormal
        e_st = 4'h0;
        wr(2'd0, 32'h10); wait_idle();
        c_addr_nak = 1; run("R5 start nak idle", 5'h1F, 6'h00);
        rd(2'd0, d); chk("R5 start code kept", {28'd0, d[19:16]}, 32'h1);
        c_addr_nak = 0;
        run("R9 stop after nak", 5'h10, 6'h10);

        // R6 data NAK ends transfer with stop op; R7 read error
        run("open2", 5'h01, 6'h00);
        c_data_nak = 1; tx = 8'h77; run("R6 data nak", 5'h02, 6'h02);
        c_data_nak = 0; c_rerr = 1; run("R7 read error", 5'h04, 6'h04);
        c_rerr = 0;

        // R10 write-1-to-clear
        run("w1c setup", 5'h15, 6'h00);
        wr(2'd2, 32'h1);
        rd(2'd2, d); chk("R10 w1c clears only written bit", {26'd0, d[5:0]}, {26'd0, e_flags & 6'h3E});

        // R12 write while busy dropped
        c_delay = 3; tx = 8'h90;
        wr(2'd3, 32'h20);
        wr(2'd1, {24'd0, tx});
        l_n = 0; model_cmd(5'h13);
        wr(2'd0, 32'h13);
        wr(2'd0, 32'h04);
        wait_idle();
        compare("R12 drop", 6'h20, 6'h20);
        c_delay = 1;

        // random mix
        for (int it = 0; it < 60; it++) begin
            logic [4:0] c;
            logic [5:0] en;
            c = 5'($urandom);
            en = 6'($urandom);
            c_addr_nak = ($urandom % 4) == 0;
            c_data_nak = ($urandom % 4) == 0;
            c_rerr     = ($urandom % 5) == 0;
            c_rx       = 8'($urandom);
            c_delay    = int'($urandom % 4);
            tx         = 8'($urandom);
            run("rand", c, en);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule